// File: doc/BRIEF.md
# Absolute Difference Accumulate Unit

This block is a 64-bit integer execution unit. It takes one 32-bit X-form instruction word per cycle together with a valid strobe, the operand values read for RA and RB, the current value of the destination register RT, and the summary-overflow bit. It supports two operations. The first writes the unsigned absolute difference of RA and RB to RT. The second adds that difference to the old RT value and writes the sum back to RT. All arithmetic wraps modulo 2^64.

The difference uses a conditional complement-and-add. When RA is unsigned-less-than RB, the unit forms NOT(RA) + RB + 1. Otherwise it forms NOT(RB) + RA + 1. When the record bit is set, the unit also produces a 4-bit condition field for CR0 and its write enable.

Results are registered, so they appear one cycle after the valid cycle. A word with the right primary opcode but an unknown extended opcode raises an illegal flag and writes nothing. The register file that reads the operands and takes the results is outside this block.

Top module: `adu_unit`

## Requirements
- R1: While synchronous active-high reset `rst` is sampled high, the next outputs have `rt_we_o`, `cr0_we_o` and `illegal_o` all low, even if a valid legal word is presented in that cycle.
- R2: The difference form applies when the primary opcode is 22 (instruction bits 31:26, which are bits 0..5 in MSB-0 numbering) and the extended opcode is 0b1011110110 (instruction bits 10:1). It yields `result_o` equal to the unsigned |RA - RB| and asserts `rt_we_o`.
- R3: The difference is symmetric in its two operands. It is zero when RA equals RB.
- R4: The accumulate form applies for extended opcode 0b1111110110. It yields `result_o` = `rt_i` + |RA - RB| modulo 2^64 and asserts `rt_we_o`.
- R5: Arithmetic wraps modulo 2^64. From RT=0, accumulating (RA=2, RB=all ones) gives 0xFFFFFFFFFFFFFFFD, and then accumulating (9,3) gives 3. Accumulating (2,1) then (9,3) from 0 gives 7, and (1,2) then (9,3) also gives 7.
- R6: When the record bit (instruction bit 0) is 1 on a legal word, `cr0_we_o` is high and `cr0_o` is {LT,GT,EQ,SO} in bits 3..0. LT and GT come from a signed comparison of the result with zero, EQ is set when the result is zero, and SO copies `so_i`. When the record bit is 0, `cr0_we_o` stays low.
- R7: A word with primary opcode 22 and any other extended opcode sets `illegal_o` and keeps `rt_we_o` and `cr0_we_o` low.
- R8: A cycle with `valid_i` low, or with a primary opcode other than 22, leaves all three flags low.
- R9: Each output flag is a one-cycle pulse. It appears in the cycle after the valid word is sampled and drops in the following cycle unless another word is issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| valid_i | input | 1 | Instruction word and operands are valid this cycle |
| instr_i | input | 32 | X-form instruction word |
| ra_i | input | 64 | Value of source register RA |
| rb_i | input | 64 | Value of source register RB |
| rt_i | input | 64 | Current value of destination register RT |
| so_i | input | 1 | Summary-overflow bit copied into CR0 |
| result_o | output | 64 | Value to be written to RT |
| rt_we_o | output | 1 | Write enable for RT |
| cr0_o | output | 4 | Condition field {LT,GT,EQ,SO} |
| cr0_we_o | output | 1 | Write enable for CR0 |
| illegal_o | output | 1 | Unsupported extended opcode under primary opcode 22 |

## Verification
The hardest cases to reach are the ones where wrapping changes the sign of the accumulated value. The first case is an accumulate that pushes RT past 2^63, so the record field must report LT. The second is a later accumulate that wraps the value back through zero. The bench reaches both by chaining accumulate words and feeding each registered result back in as the next `rt_i`, the way a register file would. It starts from a difference whose larger operand is all ones. It also issues the same chain with the first operand pair swapped, to show that operand order does not matter.

// File: rtl/adu_pkg.sv
package adu_pkg;

    localparam int          INSN_W      = 32;
    localparam int          POP_W       = 6;
    localparam int          XOP_W       = 10;
    localparam int          CRF_W       = 4;
    localparam logic [5:0]  POP_AVLANE  = 6'd22;
    localparam logic [9:0]  XOP_DIFF    = 10'b1011110110;
    localparam logic [9:0]  XOP_ACCUM   = 10'b1111110110;

    typedef enum logic [1:0] {
        K_NONE  = 2'd0,
        K_DIFF  = 2'd1,
        K_ACCUM = 2'd2,
        K_BAD   = 2'd3
    } kind_e;

    typedef struct packed {
        kind_e kind;
        logic  rec;
    } dec_t;

    typedef struct packed {
        logic lt;
        logic gt;
        logic eq;
        logic so;
    } crf_t;

    function automatic crf_t crf_make(input logic neg, input logic zero, input logic so);
        crf_t c;
        c.lt = neg;
        c.gt = !neg && !zero;
        c.eq = zero;
        c.so = so;
        return c;
    endfunction

endpackage

// File: rtl/adu_decode.sv
module adu_decode
    import adu_pkg::*;
(
    input  logic             vld,
    input  logic [POP_W-1:0] pop,
    input  logic [XOP_W-1:0] xop,
    input  logic             rec,
    output dec_t             dec
);
    logic hit_pop;

    always_comb begin
        hit_pop  = vld && (pop == POP_AVLANE);
        dec.rec  = rec;
        dec.kind = K_NONE;
        if (hit_pop) begin
            unique case (xop)
                XOP_DIFF:  dec.kind = K_DIFF;
                XOP_ACCUM: dec.kind = K_ACCUM;
                default:   dec.kind = K_BAD;
            endcase
        end
    end

    // R8: no decoded operation without valid and the right primary opcode
    always_comb begin
        a_r8_kind_needs_pop: assert (dec.kind == K_NONE || (vld && pop == POP_AVLANE));
    end

endmodule

// File: rtl/adu_absdiff.sv
module adu_absdiff #(
    parameter int W = 64
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic [W-1:0] d
);
    logic          a_lt_b;
    logic [W-1:0]  lhs;
    logic [W-1:0]  rhs;

    always_comb begin
        a_lt_b = a < b;
        lhs    = a_lt_b ? ~a : ~b;
        rhs    = a_lt_b ?  b :  a;
        d      = lhs + rhs + {{(W-1){1'b0}}, 1'b1};
    end

    // R3: the difference vanishes exactly when the operands match
    always_comb begin
        a_r3_zero_iff_equal: assert ((d == '0) == (a == b));
    end

endmodule

// File: rtl/adu_accum.sv
module adu_accum
    import adu_pkg::*;
#(
    parameter int W = 64
) (
    input  kind_e        kind,
    input  logic [W-1:0] base,
    input  logic [W-1:0] diff,
    output logic [W-1:0] sum
);
    localparam int NSEL = 2;
    logic [W-1:0] cand [NSEL];

    for (genvar g = 0; g < NSEL; g++) begin : g_cand
        if (g == 0) begin : g_plain
            assign cand[g] = diff;
        end else begin : g_acc
            assign cand[g] = base + diff;
        end
    end

    assign sum = (kind == K_ACCUM) ? cand[1] : cand[0];

endmodule

// File: rtl/adu_unit.sv
module adu_unit
    import adu_pkg::*;
#(
    parameter int XLEN = 64
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            valid_i,
    input  logic [31:0]     instr_i,
    input  logic [XLEN-1:0] ra_i,
    input  logic [XLEN-1:0] rb_i,
    input  logic [XLEN-1:0] rt_i,
    input  logic            so_i,
    output logic [XLEN-1:0] result_o,
    output logic            rt_we_o,
    output logic [3:0]      cr0_o,
    output logic            cr0_we_o,
    output logic            illegal_o
);
    localparam int POP_LSB = INSN_W - POP_W;
    localparam int XOP_LSB = 1;

    dec_t            dec;
    logic [XLEN-1:0] diff;
    logic [XLEN-1:0] sum;
    crf_t            crf_n;
    logic            legal;

    adu_decode u_dec (
        .vld (valid_i),
        .pop (instr_i[INSN_W-1:POP_LSB]),
        .xop (instr_i[XOP_LSB+XOP_W-1:XOP_LSB]),
        .rec (instr_i[0]),
        .dec (dec)
    );

    adu_absdiff #(.W(XLEN)) u_diff (
        .a (ra_i),
        .b (rb_i),
        .d (diff)
    );

    adu_accum #(.W(XLEN)) u_acc (
        .kind (dec.kind),
        .base (rt_i),
        .diff (diff),
        .sum  (sum)
    );

    always_comb begin
        legal = (dec.kind == K_DIFF) || (dec.kind == K_ACCUM);
        crf_n = crf_make(sum[XLEN-1], sum == '0, so_i);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            result_o  <= '0;
            rt_we_o   <= 1'b0;
            cr0_o     <= '0;
            cr0_we_o  <= 1'b0;
            illegal_o <= 1'b0;
        end else begin
            rt_we_o   <= legal;
            cr0_we_o  <= legal && dec.rec;
            illegal_o <= dec.kind == K_BAD;
            if (legal) begin
                result_o <= sum;
                cr0_o    <= crf_n;
            end
        end
    end

    // R7: an illegal word never writes anything
    a_r7_illegal_silent: assert property (@(posedge clk) disable iff (rst)
        illegal_o |-> (!rt_we_o && !cr0_we_o));

    // R6: the condition field is written only alongside the register
    a_r6_cr_with_rt: assert property (@(posedge clk) disable iff (rst)
        cr0_we_o |-> rt_we_o);

    // R6: a written zero result reports EQ and nothing else of LT/GT
    a_r6_eq_on_zero: assert property (@(posedge clk) disable iff (rst)
        (cr0_we_o && result_o == '0) |-> (cr0_o[3:1] == 3'b001));

    // R9: every flag follows a valid word of the previous cycle
    a_r9_pulse_after_valid: assert property (@(posedge clk) disable iff (rst)
        (rt_we_o || illegal_o) |-> $past(valid_i));

    // R9: flags never overlap
    a_r9_flags_exclusive: assert property (@(posedge clk) disable iff (rst)
        $onehot0({rt_we_o, illegal_o}));

endmodule

// File: tb/sim_adu_unit.sv
module sim_adu_unit;
    logic        clk = 1'b0;
    logic        rst;
    logic        valid_i;
    logic [31:0] instr_i;
    logic [63:0] ra_i, rb_i, rt_i;
    logic        so_i;
    logic [63:0] result_o;
    logic        rt_we_o;
    logic [3:0]  cr0_o;
    logic        cr0_we_o;
    logic        illegal_o;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    localparam logic [9:0] XD = 10'b1011110110;
    localparam logic [9:0] XA = 10'b1111110110;
    localparam logic [9:0] XV = 10'b1101001110;
    localparam logic [63:0] ONES = 64'hFFFF_FFFF_FFFF_FFFF;

    always #4 clk = ~clk;

    adu_unit u0 (
        .clk(clk), .rst(rst), .valid_i(valid_i), .instr_i(instr_i),
        .ra_i(ra_i), .rb_i(rb_i), .rt_i(rt_i), .so_i(so_i),
        .result_o(result_o), .rt_we_o(rt_we_o), .cr0_o(cr0_o),
        .cr0_we_o(cr0_we_o), .illegal_o(illegal_o)
    );

    function automatic logic [31:0] mk(input logic [5:0] pop, input logic [9:0] xo, input logic rc);
        return {pop, 5'd3, 5'd1, 5'd2, xo, rc};
    endfunction

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // drive one word at a falling edge, sample one cycle later at the next falling edge
    task automatic issue(input logic [31:0] w, input logic [63:0] a, input logic [63:0] b,
                         input logic [63:0] t, input logic so);
        @(negedge clk);
        valid_i = 1'b1; instr_i = w; ra_i = a; rb_i = b; rt_i = t; so_i = so;
        @(negedge clk);
        valid_i = 1'b0;
    endtask

    task automatic t_reset;
        rst = 1'b1;
        issue(mk(6'd22, XD, 1'b1), 64'd9, 64'd3, 64'd0, 1'b0);
        chk("R1 rt_we", {63'd0, rt_we_o}, 64'd0);
        chk("R1 cr_we", {63'd0, cr0_we_o}, 64'd0);
        chk("R1 illegal", {63'd0, illegal_o}, 64'd0);
        @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic t_diff;
        issue(mk(6'd22, XD, 1'b0), 64'd9, 64'd3, 64'd100, 1'b0);
        chk("R2 diff 9,3", result_o, 64'd6);
        chk("R2 we", {63'd0, rt_we_o}, 64'd1);
        chk("R6 rc0 no cr", {63'd0, cr0_we_o}, 64'd0);
        issue(mk(6'd22, XD, 1'b0), 64'd3, 64'd9, 64'd100, 1'b0);
        chk("R3 diff 3,9", result_o, 64'd6);
        issue(mk(6'd22, XD, 1'b0), 64'd5, 64'd5, 64'd7, 1'b0);
        chk("R3 equal", result_o, 64'd0);
        issue(mk(6'd22, XD, 1'b0), 64'd0, ONES, 64'd0, 1'b0);
        chk("R2 full span", result_o, ONES);
    endtask

    task automatic t_accum_chain(input logic [63:0] a0, input logic [63:0] b0,
                                 input logic [63:0] mid, input logic [63:0] fin);
        logic [63:0] t;
        issue(mk(6'd22, XA, 1'b0), a0, b0, 64'd0, 1'b0);
        chk("R4 first step", result_o, mid);
        chk("R4 we", {63'd0, rt_we_o}, 64'd1);
        t = result_o;
        issue(mk(6'd22, XA, 1'b0), 64'd9, 64'd3, t, 1'b0);
        chk("R5 chain", result_o, fin);
    endtask

    task automatic t_record;
        issue(mk(6'd22, XA, 1'b1), 64'd2, ONES, 64'd0, 1'b1);
        chk("R6 cr_we", {63'd0, cr0_we_o}, 64'd1);
        chk("R6 neg so", {60'd0, cr0_o}, 64'h9);
        issue(mk(6'd22, XD, 1'b1), 64'd4, 64'd4, 64'd0, 1'b0);
        chk("R6 zero", {60'd0, cr0_o}, 64'h2);
        issue(mk(6'd22, XD, 1'b1), 64'd4, 64'd1, 64'd0, 1'b1);
        chk("R6 pos", {60'd0, cr0_o}, 64'h5);
    endtask

    task automatic t_illegal;
        issue(mk(6'd22, XV, 1'b1), 64'd9, 64'd3, 64'd0, 1'b0);
        chk("R7 illegal", {63'd0, illegal_o}, 64'd1);
        chk("R7 no rt", {63'd0, rt_we_o}, 64'd0);
        chk("R7 no cr", {63'd0, cr0_we_o}, 64'd0);
    endtask

    task automatic t_ignore;
        issue(mk(6'd31, XD, 1'b1), 64'd9, 64'd3, 64'd0, 1'b0);
        chk("R8 other pop", {61'd0, rt_we_o, cr0_we_o, illegal_o}, 64'd0);
        @(negedge clk);
        instr_i = mk(6'd22, XV, 1'b1);
        @(negedge clk);
        chk("R8 no valid", {61'd0, rt_we_o, cr0_we_o, illegal_o}, 64'd0);
    endtask

    task automatic t_pulse;
        issue(mk(6'd22, XD, 1'b1), 64'd8, 64'd1, 64'd0, 1'b0);
        chk("R9 pulse on", {62'd0, rt_we_o, cr0_we_o}, 64'd3);
        @(negedge clk);
        chk("R9 pulse off", {62'd0, rt_we_o, cr0_we_o}, 64'd0);
    endtask

    initial begin
        valid_i = 1'b0; instr_i = '0; ra_i = '0; rb_i = '0; rt_i = '0; so_i = 1'b0; rst = 1'b1;
        repeat (2) @(negedge clk);
        t_reset;
        t_diff;
        t_accum_chain(64'd2, 64'd1, 64'd1, 64'd7);
        t_accum_chain(64'd1, 64'd2, 64'd1, 64'd7);
        t_accum_chain(64'd2, ONES, 64'hFFFF_FFFF_FFFF_FFFD, 64'd3);
        t_record;
        t_illegal;
        t_ignore;
        t_pulse;
        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual hung expected done");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule